// File: doc/BRIEF.md
# Adaptive FSK Data Slicer

The slicer takes signed instantaneous-frequency samples from an FSK discriminator, measured relative to the IF, and turns each one into a hard data bit. It does not assume that the two tones sit symmetrically about the IF. Instead it follows the frequency excursions of the signal. It records a swing only when the frequency moves away from the latest peak by more than a programmable expected deviation. At each swing it hands the peak it just left to an estimator. The estimator takes the midpoint of the latest maximum and the latest minimum as the decision level.

The estimate becomes available after the third recorded swing. After that, the midpoints are averaged in blocks whose length is set by a settling code. A settling code of zero bypasses the estimator and slices against zero. The current decision level is also driven out as a signed frequency-offset estimate, for use by an external frequency controller. Bit-clock recovery and line decoding happen downstream.

Top module: `fsk_slicer`

## Requirements
- R1: The expected deviation is D = `dev_man << dev_exp`. A swing is recorded only when a sample differs from the tracked extreme, in the direction opposite to the excursion, by strictly more than D.
- R2: Before the first swing, the block tracks both the lowest and the highest sample since the clear. A sample above the lowest by more than D records a swing that hands over the lowest value as a minimum. Otherwise, a sample below the highest by more than D records a swing that hands over the highest value as a maximum.
- R3: `est_ready` rises on the clock edge of the sample that records the third swing. On that edge, `offset` becomes floor((latest maximum + latest minimum) / 2).
- R4: From the third swing onwards, the midpoints are summed in blocks of N = 4, 8 or 16 swings, for settling code 01, 10 or 11. The block starts with the midpoint of the third swing. `offset` changes to floor(sum / N) only on the edge of the swing that completes a block.
- R5: On each edge with `smp_valid` high, `bit_out` is set to 1 when `smp` is greater than or equal to the `offset` value held before that edge, and to 0 otherwise.
- R6: With settling code 00, `offset` reads 0, `est_ready` reads 0, and `bit_out` gives the sign decision `smp >= 0`.
- R7: An edge with `smp_valid` low changes no output and no tracking state.
- R8: A high `rst` or `restart` at a clock edge clears `bit_out`, `est_ready` and `offset` to 0, together with the extremes, the swing count and the average.
- R9: During an excursion, the tracked extreme follows the furthest sample in that direction. A swing hands over that peak, not the sample just before the swing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| restart | input | 1 | Synchronous clear of the estimator, active high |
| smp_valid | input | 1 | Sample strobe |
| smp | input | W | Signed frequency sample relative to the IF |
| dev_exp | input | 2 | Expected-deviation exponent |
| dev_man | input | 4 | Expected-deviation mantissa |
| settle | input | 2 | Settling code: 00 bypass, 01/10/11 average over 4/8/16 swings |
| bit_out | output | 1 | Sliced data bit |
| est_ready | output | 1 | Decision level is estimated |
| offset | output | W | Signed decision level and offset estimate |

## Verification
The bench builds the block with its default sample width of 12 bits. That width covers deviations up to 15 << 3 and excursions of a few hundred counts without wrap. A sequence with settling code 01 reaches a complete four-swing average block and a following partial block. It also places samples exactly at, just under and just over the decision level. Directed runs with a deviation of 4 probe swings of exactly D, check an odd midpoint sum that needs flooring, and show the bypass code holding the level at zero while swings occur.

// File: rtl/fsk_slicer.sv
module fsk_slicer #(
  parameter int W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                restart,
  input  logic                smp_valid,
  input  logic signed [W-1:0] smp,
  input  logic        [1:0]   dev_exp,
  input  logic        [3:0]   dev_man,
  input  logic        [1:0]   settle,
  output logic                bit_out,
  output logic                est_ready,
  output logic signed [W-1:0] offset
);
  localparam int E = W + 2;
  localparam int A = W + 5;

  logic                have, dirv, up, rdy;
  logic signed [W-1:0] hi, lo, ext, lmax, lmin, thr;
  logic        [1:0]   ntr;
  logic signed [A-1:0] acc;
  logic        [4:0]   nacc;

  logic signed [E-1:0] dev, sx, hix, lox, extx, msum;
  logic                tr, hmax;
  logic signed [W-1:0] hv, nmax, nmin, mid, thr_use;
  logic        [2:0]   sh;
  logic signed [A-1:0] accn;

  assign dev  = $signed(E'(dev_man) << dev_exp);
  assign sx   = E'(smp);
  assign hix  = E'(hi);
  assign lox  = E'(lo);
  assign extx = E'(ext);

  always_comb begin
    tr = 1'b0;
    hmax = 1'b0;
    hv = ext;
    if (have) begin
      if (!dirv) begin
        if (sx - lox > dev) begin
          tr = 1'b1; hmax = 1'b0; hv = lo;
        end else if (hix - sx > dev) begin
          tr = 1'b1; hmax = 1'b1; hv = hi;
        end
      end else if (up) begin
        if (extx - sx > dev) begin
          tr = 1'b1; hmax = 1'b1;
        end
      end else if (sx - extx > dev) begin
        tr = 1'b1;
      end
    end
  end

  assign nmax = hmax ? hv : lmax;
  assign nmin = hmax ? lmin : hv;
  assign msum = E'(nmax) + E'(nmin);
  assign mid  = W'(msum >>> 1);
  assign accn = acc + A'(mid);
  assign sh   = {1'b0, settle} + 3'd1;

  assign thr_use   = (settle == 2'b00 || !rdy) ? '0 : thr;
  assign offset    = thr_use;
  assign est_ready = rdy && (settle != 2'b00);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      bit_out <= 1'b0;
      have <= 1'b0; dirv <= 1'b0; up <= 1'b0; rdy <= 1'b0;
      hi <= '0; lo <= '0; ext <= '0; lmax <= '0; lmin <= '0; thr <= '0;
      ntr <= '0; acc <= '0; nacc <= '0;
    end else if (smp_valid) begin
      bit_out <= (smp >= thr_use);
      have <= 1'b1;
      if (!have) begin
        hi <= smp; lo <= smp; ext <= smp;
      end else if (tr) begin
        dirv <= 1'b1;
        up   <= !hmax;
        ext  <= smp;
        if (hmax) lmax <= hv;
        else      lmin <= hv;
        if (ntr != 2'd3) ntr <= ntr + 2'd1;
        if (ntr == 2'd2) begin
          rdy  <= 1'b1;
          thr  <= mid;
          acc  <= A'(mid);
          nacc <= 5'd1;
        end else if (ntr == 2'd3) begin
          if (nacc + 5'd1 == (5'd1 << sh)) begin
            thr  <= W'(accn >>> sh);
            acc  <= '0;
            nacc <= '0;
          end else begin
            acc  <= accn;
            nacc <= nacc + 5'd1;
          end
        end
      end else if (!dirv) begin
        if (smp > hi) hi <= smp;
        if (smp < lo) lo <= smp;
      end else if (up) begin
        if (smp > ext) ext <= smp;
      end else if (smp < ext) begin
        ext <= smp;
      end
    end
  end
endmodule

module fsk_slicer_chk #(
  parameter int W = 12
) (
  input logic                clk,
  input logic                rst,
  input logic                restart,
  input logic                smp_valid,
  input logic signed [W-1:0] smp,
  input logic        [1:0]   dev_exp,
  input logic        [3:0]   dev_man,
  input logic        [1:0]   settle,
  input logic                bit_out,
  input logic                est_ready,
  input logic signed [W-1:0] offset
);
  logic [2:0] nseen;
  always_ff @(posedge clk) begin
    if (rst || restart) nseen <= '0;
    else if (smp_valid && nseen != 3'd7) nseen <= nseen + 3'd1;
  end

  assert_reset_clear_R8: assert property (@(posedge clk)
    rst |=> (!bit_out && !est_ready && offset == '0));

  assert_restart_clear_R8: assert property (@(posedge clk) disable iff (rst)
    restart |=> (!est_ready && offset == '0));

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!smp_valid && !restart) |=> ($stable(bit_out) && $stable(est_ready) && $stable(offset)));

  assert_bypass_sign_R6: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !restart && settle == 2'b00) |=> (bit_out == ($past(smp) >= 0)));

  assert_bypass_level_R6: assert property (@(posedge clk) disable iff (rst)
    (settle == 2'b00) |-> (!est_ready && offset == '0));

  assert_three_swings_R3: assert property (@(posedge clk) disable iff (rst)
    est_ready |-> (nseen >= 3'd4));

  assert_ready_on_sample_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(est_ready) |-> $past(smp_valid));

  logic unused_ok;
  assign unused_ok = ^{dev_exp, dev_man};
endmodule

bind fsk_slicer fsk_slicer_chk #(.W(W)) u_chk (.*);

// File: tb/fsk_slicer_bench.sv
module fsk_slicer_bench;
  localparam int W = 12;
  localparam int NV = 17;

  logic clk = 1'b0;
  logic rst = 1'b1, restart = 1'b0, smp_valid = 1'b0;
  logic signed [W-1:0] smp = '0;
  logic [1:0] dev_exp = 2'd3, settle = 2'b01;
  logic [3:0] dev_man = 4'd5;
  logic bit_out, est_ready;
  logic signed [W-1:0] offset;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fsk_slicer #(.W(W)) u_fsk_slicer (
    .clk(clk), .rst(rst), .restart(restart), .smp_valid(smp_valid), .smp(smp),
    .dev_exp(dev_exp), .dev_man(dev_man), .settle(settle),
    .bit_out(bit_out), .est_ready(est_ready), .offset(offset));

  // {valid, sample, expected bit, expected ready, expected offset}; D = 5<<3 = 40, settle 01
  localparam logic [26:0] TBL [NV] = '{
    {1'b1, 12'(10),  1'b1, 1'b0, 12'(0)},
    {1'b1, 12'(30),  1'b1, 1'b0, 12'(0)},
    {1'b1, 12'(60),  1'b1, 1'b0, 12'(0)},   // R2 first swing hands min 10
    {1'b1, 12'(90),  1'b1, 1'b0, 12'(0)},
    {1'b1, 12'(70),  1'b1, 1'b0, 12'(0)},
    {1'b1, 12'(-20), 1'b0, 1'b0, 12'(0)},   // R9 swing hands peak 90
    {1'b1, 12'(-50), 1'b0, 1'b0, 12'(0)},
    {1'b1, 12'(40),  1'b1, 1'b1, 12'(20)},  // R3 third swing, (90-50)/2
    {1'b1, 12'(25),  1'b1, 1'b1, 12'(20)},
    {1'b1, 12'(19),  1'b0, 1'b1, 12'(20)},  // R5 just under level
    {1'b1, 12'(20),  1'b1, 1'b1, 12'(20)},  // R5 equal to level
    {1'b1, 12'(-30), 1'b0, 1'b1, 12'(20)},  // R4 mid -5, no update
    {1'b1, 12'(70),  1'b1, 1'b1, 12'(20)},  // R4 mid 5
    {1'b1, 12'(-40), 1'b0, 1'b1, 12'(10)},  // R4 block done (20-5+5+20)/4
    {1'b1, 12'(10),  1'b1, 1'b1, 12'(10)},
    {1'b0, 12'(-100),1'b1, 1'b1, 12'(10)},  // R7 strobe low
    {1'b1, 12'(9),   1'b0, 1'b1, 12'(10)}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic v, input int s);
    @(negedge clk);
    smp_valid = v;
    smp = W'(s);
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  task automatic outs(input string req, input int b, input int r, input int o);
    chk({req, " bit"}, int'(bit_out), b);
    chk({req, " ready"}, int'(est_ready), r);
    chk({req, " offset"}, int'(offset), o);
  endtask

  task automatic do_restart;
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    outs("R8 reset", 0, 0, 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      step(TBL[i][26], int'($signed(TBL[i][25:14])));
      chk($sformatf("R5 row %0d bit", i), int'(bit_out), int'(TBL[i][13]));
      chk($sformatf("R3 row %0d ready", i), int'(est_ready), int'(TBL[i][12]));
      chk($sformatf("R4 row %0d offset", i), int'(offset), int'($signed(TBL[i][11:0])));
    end

    do_restart();
    outs("R8 restart", 0, 0, 0);

    // R1: D = 1<<2 = 4, swings of exactly 4 must not count
    dev_man = 4'd1; dev_exp = 2'd2;
    step(1'b1, 0); step(1'b1, 4); step(1'b1, 0);
    step(1'b1, 8); step(1'b1, 4); step(1'b1, 3);
    step(1'b1, 7);
    outs("R1 equal swing ignored", 1, 0, 0);
    step(1'b1, 8);
    outs("R1 third swing, floor of 11/2", 1, 1, 5);

    // R6: bypass code keeps level at zero while swings occur
    do_restart();
    dev_man = 4'd5; dev_exp = 2'd3; settle = 2'b00;
    step(1'b1, 10); step(1'b1, 60); step(1'b1, -50);
    step(1'b1, 40);
    outs("R6 bypass high", 1, 0, 0);
    step(1'b1, -60);
    outs("R6 bypass low", 0, 0, 0);
    step(1'b1, 0);
    outs("R6 bypass zero", 1, 0, 0);

    rst = 1'b1;
    @(negedge clk);
    outs("R8 reset again", 0, 0, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule